// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

This block is an SPI master that moves between zero and 32 bits per command, under control of a small set of memory-mapped registers. A host writes the word to send, a clock divider and a shift command. The command names which of three active-low chip selects to drive, how many bits to move, and whether to release the chip select when the bits are done. Software polls the busy bit in the command register, then reads back the received bits.

Because a burst can leave its chip select asserted, a transaction longer than 32 bits is built from several chained commands. The last command of the chain carries the terminate flag. While no burst runs, a pin-control register sets the idle levels of the chip selects, the data-out line and the serial clock directly. SPI mode 0 applies: the clock idles low, the engine samples its input on the rising edge and changes its output on the falling edge.

Top module: `spiShiftEngine`

## Requirements
- R1: After reset, csN is 3'b111, sclk and mosi are 0, the enable register (offset 0x00) reads 0, and the pin-control register (offset 0x08) reads 0x0007_0000 once the engine is enabled.
- R2: While enable bit 0 is clear, writes to every register except offset 0x00 have no effect and those registers read as 0.
- R3: A write to the command register (offset 0x14) with bit 31 set starts a burst. Bit 31 then reads 1 for exactly 2·N·(div+1) clock cycles, where N is the bit count in bits 5:0 and div is bits 5:0 of the clock register (offset 0x04).
- R4: A command write that arrives while a burst is busy, including its last busy cycle, is ignored in full.
- R5: Transmit bits are taken from the data-out register (offset 0x10), starting at bit N-1 and ending at bit 0. mosi holds steady while sclk is high.
- R6: Each sampled miso bit enters the data-in register (offset 0x18) at bit 0, and the earlier contents move up by one position.
- R7: A burst of N bits produces exactly N rising sclk edges, spaced 2·(div+1) clock cycles apart.
- R8: Command bits 30:28 select chip selects 2..0, and that selection stays fixed during the burst. With terminate (bit 26) set, the selected csN returns high when the burst ends. With terminate clear, it stays low.
- R9: After a burst starts, sclk stays low for div+1 cycles before its first rising edge.
- R10: A bit count of zero produces no sclk edge and never shows busy. It still asserts the selected chip selects, or releases them when terminate is set.
- R11: With no burst running, csN follows pin-control bits 18:16, mosi follows bit 0 and sclk follows bit 8.
- R12: A bit count above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 3 | Active-low chip selects |

## Verification
Two events can land on the same clock edge: a new command write and the edge on which the current burst finishes and busy clears. The bench aims a command at the last busy cycle of a short burst. It expects that command to be dropped: no further sclk edges, no chip select asserted, and busy low afterwards. A second case lets a chain's terminate-clear burst end while the next command is still being prepared, and checks that the held chip select survives the idle gap.

// File: rtl/spiShiftPkg.sv
package spiShiftPkg;
  localparam int unsigned OFS_ENABLE = 8'h00;
  localparam int unsigned OFS_CLKCTL = 8'h04;
  localparam int unsigned OFS_PINCTL = 8'h08;
  localparam int unsigned OFS_TXDATA = 8'h10;
  localparam int unsigned OFS_CMD    = 8'h14;
  localparam int unsigned OFS_RXDATA = 8'h18;

  localparam int unsigned CMD_GO_BIT   = 31;
  localparam int unsigned CMD_SEL_LSB  = 28;
  localparam int unsigned CMD_TERM_BIT = 26;
  localparam int unsigned PIN_CS_LSB   = 16;
  localparam int unsigned PIN_MOSI_BIT = 0;
  localparam int unsigned PIN_SCLK_BIT = 8;

  typedef struct packed {
    logic load;     // capture transmit word and bit count
    logic sample;   // take one miso bit (rising sclk)
    logic advance;  // step to next transmit bit (falling sclk)
  } shiftStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } shiftState_t;
endpackage

// File: rtl/spiRegBank.sv
module spiRegBank
  import spiShiftPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CS_N   = 3,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              busy,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DIV_W-1:0]  divSet,
  output logic [31:0]       pinCtl,
  output logic [DATA_W-1:0] txWord,
  output logic              startReq,
  output logic [CNT_W-1:0]  reqCount,
  output logic [CS_N-1:0]   reqSel,
  output logic              reqTerm
);
  localparam logic [31:0] PIN_RESET = {{(32-PIN_CS_LSB-CS_N){1'b0}}, {CS_N{1'b1}}, {PIN_CS_LSB{1'b0}}};

  logic enable;
  logic wrEnable, wrClk, wrPin, wrTx, wrCmd;

  assign wrEnable = busWrEn && (busAddr == ADDR_W'(OFS_ENABLE));
  assign wrClk    = busWrEn && enable && (busAddr == ADDR_W'(OFS_CLKCTL));
  assign wrPin    = busWrEn && enable && (busAddr == ADDR_W'(OFS_PINCTL));
  assign wrTx     = busWrEn && enable && (busAddr == ADDR_W'(OFS_TXDATA));
  assign wrCmd    = busWrEn && enable && !busy && (busAddr == ADDR_W'(OFS_CMD));

  assign startReq = wrCmd && busWrData[CMD_GO_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      divSet   <= '0;
      pinCtl   <= PIN_RESET;
      txWord   <= '0;
      reqCount <= '0;
      reqSel   <= '0;
      reqTerm  <= 1'b0;
    end else begin
      if (wrEnable) enable <= busWrData[0];
      if (wrClk)    divSet <= busWrData[DIV_W-1:0];
      if (wrPin)    pinCtl <= busWrData;
      if (wrTx)     txWord <= busWrData[DATA_W-1:0];
      if (wrCmd) begin
        reqCount <= busWrData[CNT_W-1:0];
        reqSel   <= busWrData[CMD_SEL_LSB +: CS_N];
        reqTerm  <= busWrData[CMD_TERM_BIT];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(OFS_ENABLE)) begin
      busRdData[0] = enable;
    end else if (enable) begin
      case (busAddr)
        ADDR_W'(OFS_CLKCTL): busRdData[DIV_W-1:0] = divSet;
        ADDR_W'(OFS_PINCTL): busRdData = pinCtl;
        ADDR_W'(OFS_TXDATA): busRdData[DATA_W-1:0] = txWord;
        ADDR_W'(OFS_RXDATA): busRdData[DATA_W-1:0] = rxWord;
        ADDR_W'(OFS_CMD): begin
          busRdData[CMD_GO_BIT]             = busy;
          busRdData[CMD_SEL_LSB +: CS_N]    = reqSel;
          busRdData[CMD_TERM_BIT]           = reqTerm;
          busRdData[CNT_W-1:0]              = reqCount;
        end
        default: busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/spiShiftCtrl.sv
module spiShiftCtrl
  import spiShiftPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CS_N   = 3,
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  reqCountRaw,
  input  logic [CS_N-1:0]   reqSelNow,
  input  logic              reqTermNow,
  input  logic [DIV_W-1:0]  divSet,
  output logic              busy,
  output logic              sclkHigh,
  output logic [CS_N-1:0]   csHold,
  output logic [CNT_W-1:0]  burstLen,
  output logic [CNT_W-1:0]  loadCount,
  output shiftStrobe_t      strobe
);
  localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);

  shiftState_t     state;
  logic [DIV_W-1:0] halfCnt, divLat;
  logic [CNT_W-1:0] bitsLeft;
  logic             termLat;
  logic             halfDone;

  assign loadCount = (reqCountRaw > MAX_BITS) ? MAX_BITS : reqCountRaw;
  assign halfDone  = (halfCnt == divLat);
  assign busy      = (state != ST_IDLE);
  assign sclkHigh  = (state == ST_HIGH);

  always_comb begin
    strobe.load    = startReq && (loadCount != '0);
    strobe.sample  = ((state == ST_LEAD) || (state == ST_LOW)) && halfDone;
    strobe.advance = (state == ST_HIGH) && halfDone && (bitsLeft != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      divLat   <= '0;
      bitsLeft <= '0;
      termLat  <= 1'b0;
      csHold   <= '0;
      burstLen <= '0;
    end else if (startReq) begin
      if (loadCount == '0) begin
        csHold <= reqTermNow ? '0 : reqSelNow;
      end else begin
        state    <= ST_LEAD;
        halfCnt  <= '0;
        divLat   <= divSet;
        bitsLeft <= loadCount;
        termLat  <= reqTermNow;
        csHold   <= reqSelNow;
        burstLen <= loadCount;
      end
    end else begin
      case (state)
        ST_LEAD, ST_LOW: begin
          if (halfDone) begin
            halfCnt  <= '0;
            state    <= ST_HIGH;
            bitsLeft <= bitsLeft - 1'b1;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            halfCnt <= '0;
            if (bitsLeft == '0) begin
              state <= ST_IDLE;
              if (termLat) csHold <= '0;
            end else begin
              state <= ST_LOW;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: halfCnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spiShiftData.sv
module spiShiftData
  import spiShiftPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strobe,
  input  logic [DATA_W-1:0] txWordIn,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic              miso,
  output logic              txBit,
  output logic [DATA_W-1:0] rxWord
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] txLat;
  logic [IDX_W-1:0]  bitIdx;

  assign txBit = txLat[bitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLat  <= '0;
      bitIdx <= '0;
      rxWord <= '0;
    end else begin
      if (strobe.load) begin
        txLat  <= txWordIn;
        bitIdx <= IDX_W'(loadCount - 1'b1);
      end else if (strobe.advance) begin
        bitIdx <= bitIdx - 1'b1;
      end
      if (strobe.sample) rxWord <= {rxWord[DATA_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spiShiftEngine.sv
module spiShiftEngine
  import spiShiftPkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CS_N   = 3,
  parameter int unsigned DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   csN
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic              busy, sclkHigh, txBit, startReq, reqTerm;
  logic [DIV_W-1:0]  divSet;
  logic [31:0]       pinCtl;
  logic [DATA_W-1:0] txWord, rxWord;
  logic [CNT_W-1:0]  reqCount, burstLen, loadCount;
  logic [CS_N-1:0]   reqSel, csHold, reqSelNow;
  logic              reqTermNow;
  shiftStrobe_t      strobe;

  assign reqSelNow  = busWrData[CMD_SEL_LSB +: CS_N];
  assign reqTermNow = busWrData[CMD_TERM_BIT];

  spiRegBank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .DIV_W(DIV_W), .CNT_W(CNT_W)) uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .busy(busy), .rxWord(rxWord), .divSet(divSet), .pinCtl(pinCtl),
    .txWord(txWord), .startReq(startReq), .reqCount(reqCount), .reqSel(reqSel), .reqTerm(reqTerm)
  );

  spiShiftCtrl #(.DATA_W(DATA_W), .CS_N(CS_N), .DIV_W(DIV_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqCountRaw(busWrData[CNT_W-1:0]),
    .reqSelNow(reqSelNow), .reqTermNow(reqTermNow), .divSet(divSet), .busy(busy),
    .sclkHigh(sclkHigh), .csHold(csHold), .burstLen(burstLen), .loadCount(loadCount),
    .strobe(strobe)
  );

  spiShiftData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWordIn(txWord), .loadCount(loadCount),
    .miso(miso), .txBit(txBit), .rxWord(rxWord)
  );

  assign sclk = busy ? sclkHigh : pinCtl[PIN_SCLK_BIT];
  assign mosi = busy ? txBit : pinCtl[PIN_MOSI_BIT];
  assign csN  = pinCtl[PIN_CS_LSB +: CS_N] & ~csHold;

  logic unusedBits;
  assign unusedBits = ^{reqCount, reqSel, reqTerm};
endmodule

// File: rtl/spiShiftEngineChk.sv
module spiShiftEngineChk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CS_N   = 3,
  parameter int unsigned CNT_W  = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             sclk,
  input logic             mosi,
  input logic [CS_N-1:0]  csHold,
  input logic [CNT_W-1:0] burstLen
);
  // R5: transmit line only moves while the clock is low
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(mosi));

  // R9: the first busy cycle shows a low clock
  p_lead_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> !sclk);

  // R8: chip-select choice is frozen for the duration of a burst
  p_cs_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csHold));

  // R10: a zero-length command never creates a busy burst
  p_len_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (burstLen != '0));

  // R12: latched length never exceeds the word width
  p_len_cap_r12: assert property (@(posedge clk) disable iff (!rstN)
    burstLen <= CNT_W'(DATA_W));
endmodule

bind spiShiftEngine spiShiftEngineChk #(.DATA_W(DATA_W), .CS_N(CS_N), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk), .mosi(mosi),
  .csHold(csHold), .burstLen(burstLen)
);

// File: tb/spiShiftEngine_test.sv
module spiShiftEngine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        sclk, mosi, miso;
  logic [2:0]  csN;

  int checks = 0;
  int fails = 0;

  spiShiftEngine uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always #4 clk = ~clk;

  // slave model
  int          rises = 0;
  int          falls = 0;
  logic [31:0] capWord = '0;
  time         prevRise = 0;
  time         lastPeriod = 0;
  logic [31:0] slvWord = '0;
  int          fallBase = 0;

  assign miso = slvWord[31 - ((falls - fallBase) % 32)];

  always @(posedge sclk) begin
    capWord    = {capWord[30:0], mosi};
    lastPeriod = $time - prevRise;
    prevRise   = $time;
    rises      = rises + 1;
  end
  always @(negedge sclk) falls = falls + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] cmdWord(input logic [2:0] sel, input logic term, input logic [5:0] cnt);
    return {1'b1, sel, 1'b0, term, 20'd0, cnt};
  endfunction

  int measBusy, measLead;

  task automatic runBurst(input logic [2:0] sel, input logic term, input logic [5:0] cnt,
                          input logic [5:0] dv, input logic [31:0] word, input logic [31:0] slv);
    logic [31:0] rd;
    logic seenHigh;
    busWrite(8'h04, {26'd0, dv});
    busWrite(8'h10, word);
    slvWord  = slv;
    fallBase = falls;
    busWrite(8'h14, cmdWord(sel, term, cnt));
    measBusy = 0; measLead = 0; seenHigh = 1'b0;
    busRead(8'h14, rd);
    while (rd[31]) begin
      measBusy++;
      if (!seenHigh) begin
        if (sclk) seenHigh = 1'b1; else measLead++;
      end
      @(negedge clk);
      busRead(8'h14, rd);
    end
  endtask

  task automatic testReset;
    logic [31:0] rd;
    chk("R1 csN", {29'd0, csN}, 32'h7);
    chk("R1 sclk", {31'd0, sclk}, 0);
    chk("R1 mosi", {31'd0, mosi}, 0);
    busRead(8'h00, rd); chk("R1 enable", rd, 0);
  endtask

  task automatic testGate;
    logic [31:0] rd;
    int r0;
    r0 = rises;
    busWrite(8'h10, 32'h1234);
    busWrite(8'h14, cmdWord(3'b001, 1'b0, 6'd8));
    @(negedge clk);
    chk("R2 csN untouched", {29'd0, csN}, 32'h7);
    busRead(8'h10, rd); chk("R2 read while disabled", rd, 0);
    busWrite(8'h00, 32'h1);
    busRead(8'h10, rd); chk("R2 tx not written", rd, 0);
    busRead(8'h14, rd); chk("R2 no burst", rd, 0);
    chk("R2 no sclk", rises - r0, 0);
    busRead(8'h08, rd); chk("R1 pinctl reset", rd, 32'h0007_0000);
  endtask

  task automatic testBasic;
    logic [31:0] rd;
    int r0;
    r0 = rises;
    runBurst(3'b001, 1'b1, 6'd8, 6'd1, 32'h0000_003C, 32'hA500_0000);
    chk("R5 tx bits", capWord & 32'hFF, 32'h3C);
    busRead(8'h18, rd); chk("R6 rx low byte", rd & 32'hFF, 32'hA5);
    chk("R7 rising edges", rises - r0, 8);
    chk("R7 period", 32'(lastPeriod), 32);
    chk("R3 busy cycles", measBusy, 32);
    chk("R9 lead cycles", measLead, 2);
    chk("R8 released", {29'd0, csN}, 32'h7);
  endtask

  task automatic testChain;
    logic [31:0] rd;
    runBurst(3'b010, 1'b0, 6'd16, 6'd0, 32'h0000_BEEF, 32'h1200_0000);
    chk("R8 held low", {29'd0, csN}, 32'h5);
    repeat (3) @(negedge clk);
    chk("R8 held in gap", {29'd0, csN}, 32'h5);
    runBurst(3'b010, 1'b1, 6'd8, 6'd0, 32'h0000_0042, 32'h3400_0000);
    chk("R5 chained tx", capWord & 32'hFF_FFFF, 32'hBEEF42);
    busRead(8'h18, rd); chk("R6 chained rx", rd & 32'hFF_FFFF, 32'h120034);
    chk("R8 chain end", {29'd0, csN}, 32'h7);
    chk("R7 fast period", 32'(lastPeriod), 16);
  endtask

  task automatic testIgnore;
    logic [31:0] rd;
    int r0;
    // mid-burst command
    r0 = rises;
    busWrite(8'h04, 32'd3);
    busWrite(8'h14, cmdWord(3'b100, 1'b1, 6'd8));
    repeat (10) @(negedge clk);
    busWrite(8'h14, cmdWord(3'b001, 1'b0, 6'd4));
    busRead(8'h14, rd);
    while (rd[31]) begin @(negedge clk); busRead(8'h14, rd); end
    chk("R4 mid-burst count kept", rd & 32'h3F, 8);
    chk("R4 mid-burst edges", rises - r0, 8);
    chk("R4 mid-burst cs", {29'd0, csN}, 32'h7);
    // command on the last busy cycle
    r0 = rises;
    busWrite(8'h04, 32'd0);
    busWrite(8'h14, cmdWord(3'b100, 1'b1, 6'd2));
    repeat (3) @(negedge clk);
    busWrite(8'h14, cmdWord(3'b001, 1'b0, 6'd4));
    repeat (4) @(negedge clk);
    busRead(8'h14, rd);
    chk("R4 last-cycle busy", {31'd0, rd[31]}, 0);
    chk("R4 last-cycle edges", rises - r0, 2);
    chk("R4 last-cycle cs", {29'd0, csN}, 32'h7);
  endtask

  task automatic testZero;
    logic [31:0] rd;
    int r0;
    r0 = rises;
    busWrite(8'h14, cmdWord(3'b001, 1'b0, 6'd0));
    busRead(8'h14, rd);
    chk("R10 no busy", {31'd0, rd[31]}, 0);
    chk("R10 cs asserted", {29'd0, csN}, 32'h6);
    busWrite(8'h14, cmdWord(3'b001, 1'b1, 6'd0));
    chk("R10 cs released", {29'd0, csN}, 32'h7);
    chk("R10 no sclk", rises - r0, 0);
  endtask

  task automatic testClamp;
    logic [31:0] rd;
    int r0;
    r0 = rises;
    runBurst(3'b001, 1'b1, 6'd63, 6'd0, 32'hDEAD_BEEF, 32'h1357_2468);
    chk("R12 edges", rises - r0, 32);
    chk("R12 tx word", capWord, 32'hDEAD_BEEF);
    busRead(8'h18, rd); chk("R12 rx word", rd, 32'h1357_2468);
    chk("R3 busy 32 bits", measBusy, 64);
  endtask

  task automatic testPins;
    busWrite(8'h08, 32'h0002_0101);
    chk("R11 csN", {29'd0, csN}, 32'h2);
    chk("R11 mosi", {31'd0, mosi}, 1);
    chk("R11 sclk", {31'd0, sclk}, 1);
    busWrite(8'h08, 32'h0007_0000);
    chk("R11 restored", {29'd0, csN, mosi, sclk}, 32'h1C);
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testGate;
    testBasic;
    testChain;
    testIgnore;
    testZero;
    testClamp;
    testPins;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule